// File: doc/BRIEF.md
# Byte-Lane Data Parity Generator and Checker

This block protects a data bus made of byte lanes with one parity line per lane. On a write the block produces the parity bits that travel with the write data. On a read it recomputes parity from the returned data and compares it with the returned parity lines. Any mismatch sets a registered error flag.

Only the lanes that the access actually uses take part in generation and checking. The parity sense, odd or even, is chosen by a configuration input. A second configuration input can switch read checking off. The error flag describes the most recent read. It stays at that value until another read completes or reset is applied. Bus arbitration and error recovery belong to the surrounding logic.

Top module: `lane_parity_unit`

## Requirements
- R1: Parity bit i covers data bits 8i+7 down to 8i. With the default four lanes, bit 3 covers bits 31:24 and bit 0 covers bits 7:0.
- R2: When `cfg_odd` is 0, each generated parity bit of an enabled lane makes the lane's data bits plus that parity bit hold an even number of ones.
- R3: When `cfg_odd` is 1, each generated parity bit of an enabled lane makes the lane's data bits plus that parity bit hold an odd number of ones.
- R4: A lane whose `lane_en` bit is 0 drives 0 on its `wr_par` bit. `wr_par` is combinational from `wr_data`, `cfg_odd` and `lane_en`.
- R5: A read is a cycle with `xfer_valid`=1 and `xfer_write`=0. While `cfg_chk_en`=1, `par_err` becomes 1 on the clock edge after that read when any enabled lane of `rd_par` differs from the parity expected for `rd_data`. The expected parity uses the sense selected by R2/R3. Otherwise `par_err` becomes 0 on that edge.
- R6: Parity bits and data of lanes whose `lane_en` bit is 0 have no effect on `par_err`. A read with `lane_en`=0 leaves `par_err` at 0.
- R7: A read taken while `cfg_chk_en`=0 leaves `par_err` at 0 on the next edge.
- R8: A write cycle (`xfer_valid`=1, `xfer_write`=1) never changes `par_err`.
- R9: While `xfer_valid`=0, `par_err` holds its value.
- R10: An active-low reset `rst_n` clears `par_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_valid | input | 1 | A transfer completes in this cycle |
| xfer_write | input | 1 | 1 = write, 0 = read |
| lane_en | input | LANES | Byte lanes used by the access |
| cfg_chk_en | input | 1 | 1 = check parity on reads |
| cfg_odd | input | 1 | 1 = odd parity, 0 = even parity |
| wr_data | input | LANES*LANE_W | Write data |
| rd_data | input | LANES*LANE_W | Returned read data |
| rd_par | input | LANES | Returned read parity |
| wr_par | output | LANES | Generated write parity |
| par_err | output | 1 | Registered read parity error flag |

## Verification
The bench builds the block with its defaults of four lanes of eight bits. With that width, all sixteen lane masks can be reached by random stimulus, alongside both polarities and both check settings. Directed cases place a single corrupted parity bit on each lane in turn, both inside and outside the enabled mask. They also cover the flag holding across writes and idle cycles, and a clean read clearing it.

// File: rtl/lane_parity_pkg.sv
package lane_parity_pkg;
    // Registered state of the checker
    typedef struct packed {
        logic err;
    } par_state_t;
endpackage

// File: rtl/lane_parity_gen.sv
// Per-lane parity generation with polarity and lane mask (R1-related lane slicing, R2, R3, R4)
module lane_parity_gen #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int BUS_W = LANES * LANE_W
) (
    input  logic [BUS_W-1:0] data,
    input  logic             odd,
    input  logic [LANES-1:0] lane_en,
    output logic [LANES-1:0] par
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // R1: lane g covers bits g*LANE_W+LANE_W-1 .. g*LANE_W
        assign par[g] = lane_en[g] & ((^data[g*LANE_W +: LANE_W]) ^ odd);
    end
endmodule

// File: rtl/lane_parity_cmp.sv
// Compares expected and returned parity on enabled lanes only (R6)
module lane_parity_cmp #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] exp_par,
    input  logic [LANES-1:0] got_par,
    input  logic [LANES-1:0] lane_en,
    output logic             mismatch
);
    logic [LANES-1:0] lane_bad;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bad[g] = lane_en[g] & (exp_par[g] ^ got_par[g]);
    end

    assign mismatch = |lane_bad;
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
    import lane_parity_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int BUS_W = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_valid,
    input  logic             xfer_write,
    input  logic [LANES-1:0] lane_en,
    input  logic             cfg_chk_en,
    input  logic             cfg_odd,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [BUS_W-1:0] rd_data,
    input  logic [LANES-1:0] rd_par,
    output logic [LANES-1:0] wr_par,
    output logic             par_err
);
    par_state_t       st_d, st_q;
    logic [LANES-1:0] rd_exp;
    logic             rd_bad;

    // Write side parity (R2, R3, R4)
    lane_parity_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_gen_wr (
        .data    (wr_data),
        .odd     (cfg_odd),
        .lane_en (lane_en),
        .par     (wr_par)
    );

    // Expected parity for returned data
    lane_parity_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_gen_rd (
        .data    (rd_data),
        .odd     (cfg_odd),
        .lane_en (lane_en),
        .par     (rd_exp)
    );

    lane_parity_cmp #(.LANES(LANES)) u_cmp (
        .exp_par  (rd_exp),
        .got_par  (rd_par),
        .lane_en  (lane_en),
        .mismatch (rd_bad)
    );

    // Next state: only a completed read updates the flag (R5, R7, R8, R9)
    always_comb begin
        st_d = st_q;
        if (xfer_valid && !xfer_write) begin
            st_d.err = cfg_chk_en & rd_bad;
        end
    end

    // R10: reset clears the flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign par_err = st_q.err;
endmodule

// File: rtl/lane_parity_chk.sv
module lane_parity_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_valid,
    input logic             xfer_write,
    input logic [LANES-1:0] lane_en,
    input logic             cfg_chk_en,
    input logic [LANES-1:0] wr_par,
    input logic             par_err
);
    p_unused_lane_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_par & ~lane_en) == '0);

    p_no_lane_no_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_write && lane_en == '0) |=> !par_err);

    p_chk_off_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_write && !cfg_chk_en) |=> !par_err);

    p_write_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_write) |=> $stable(par_err));

    p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_valid |=> $stable(par_err));
endmodule

bind lane_parity_unit lane_parity_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_valid (xfer_valid),
    .xfer_write (xfer_write),
    .lane_en    (lane_en),
    .cfg_chk_en (cfg_chk_en),
    .wr_par     (wr_par),
    .par_err    (par_err)
);

// File: tb/lane_parity_unit_tb_top.sv
`timescale 1ns/1ps
module lane_parity_unit_tb_top;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int BUS_W  = LANES * LANE_W;

    logic             clk = 0;
    logic             rst_n = 0;
    logic             xfer_valid = 0, xfer_write = 0;
    logic [LANES-1:0] lane_en = '0;
    logic             cfg_chk_en = 0, cfg_odd = 0;
    logic [BUS_W-1:0] wr_data = '0, rd_data = '0;
    logic [LANES-1:0] rd_par = '0;
    logic [LANES-1:0] wr_par;
    logic             par_err;

    int  n_tests = 0, n_fail = 0;
    bit  err_model = 0;
    bit  done = 0;

    always #5 clk = ~clk;

    lane_parity_unit #(.LANES(LANES), .LANE_W(LANE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_write(xfer_write),
        .lane_en(lane_en), .cfg_chk_en(cfg_chk_en), .cfg_odd(cfg_odd),
        .wr_data(wr_data), .rd_data(rd_data), .rd_par(rd_par),
        .wr_par(wr_par), .par_err(par_err)
    );

    // Reference parity: count ones per lane, pick bit that gives requested sense
    function automatic logic [LANES-1:0] ref_par(input logic [BUS_W-1:0] d,
                                                 input logic odd, input logic [LANES-1:0] en);
        logic [LANES-1:0] r = '0;
        for (int l = 0; l < LANES; l++) begin
            int ones = 0;
            for (int b = 0; b < LANE_W; b++) ones += int'(d[l*LANE_W + b]);
            if (en[l]) r[l] = odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
        end
        return r;
    endfunction

    task automatic check_par(input string req);
        logic [LANES-1:0] e = ref_par(wr_data, cfg_odd, lane_en);
        n_tests++;
        if (wr_par !== e) begin
            n_fail++;
            $display("FAIL %s wr_par=%h expected=%h", req, wr_par, e);
        end
    endtask

    task automatic check_err(input string req);
        n_tests++;
        if (par_err !== err_model) begin
            n_fail++;
            $display("FAIL %s par_err=%0b expected=%0b", req, par_err, err_model);
        end
    endtask

    // Drive one cycle at negedge, update the model for the coming posedge
    task automatic cycle(input bit v, input bit w, input logic [LANES-1:0] en,
                         input bit chk, input bit odd, input logic [BUS_W-1:0] d,
                         input logic [LANES-1:0] flip);
        xfer_valid = v; xfer_write = w; lane_en = en; cfg_chk_en = chk; cfg_odd = odd;
        wr_data = d; rd_data = d;
        rd_par = ref_par(d, odd, en) ^ flip;
        if (v && !w) err_model = chk && (((rd_par ^ ref_par(d, odd, en)) & en) != '0);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check_err("R10 reset");
        rst_n = 1;
        @(negedge clk);

        // R1, R2, R3: directed lane mapping and polarity
        cfg_odd = 0; lane_en = 4'b1111; wr_data = 32'h0100_0000; #1; check_par("R1 R2 lane3 even");
        if (wr_par !== 4'b1000) begin n_fail++; $display("FAIL R1 wr_par=%h expected=8", wr_par); end
        n_tests++;
        cfg_odd = 1; #1; check_par("R3 odd");
        if (wr_par !== 4'b0111) begin n_fail++; $display("FAIL R3 wr_par=%h expected=7", wr_par); end
        n_tests++;
        lane_en = 4'b0101; wr_data = 32'hFFFF_FFFF; #1; check_par("R4 masked lanes");

        // R5: single bad lane per lane, then clean read clears
        for (int l = 0; l < LANES; l++) begin
            cycle(1, 0, 4'hF, 1, l[0], 32'hA5C3_0F81, 4'(1 << l));
            check_err("R5 bad lane sets");
            cycle(1, 0, 4'hF, 1, 0, 32'h1234_5678, '0);
            check_err("R5 clean read clears");
        end
        // R6: bad parity on a disabled lane ignored
        cycle(1, 0, 4'b0011, 1, 0, 32'hDEAD_BEEF, 4'b1100);
        check_err("R6 disabled lane ignored");
        cycle(1, 0, 4'b0000, 1, 1, 32'hDEAD_BEEF, 4'b1111);
        check_err("R6 no lanes");
        // R7: checking off
        cycle(1, 0, 4'hF, 1, 0, 32'h0, 4'b0001);
        check_err("R5 set before R7");
        cycle(1, 0, 4'hF, 0, 0, 32'h0, 4'b1111);
        check_err("R7 check off clears");
        // R8, R9: flag holds across write and idle
        cycle(1, 0, 4'hF, 1, 1, 32'h77, 4'b0100);
        check_err("R5 set before R8");
        cycle(1, 1, 4'hF, 1, 1, 32'h0, 4'b1111);
        check_err("R8 write holds");
        cycle(0, 0, 4'hF, 1, 1, 32'h0, 4'b1111);
        check_err("R9 idle holds");
        // R10: reset mid-run
        rst_n = 0; err_model = 0; #1; check_err("R10 async reset");
        @(negedge clk); rst_n = 1; @(negedge clk);

        // Random mix
        for (int i = 0; i < 2000; i++) begin
            logic [BUS_W-1:0] d = $urandom;
            logic [LANES-1:0] en = LANES'($urandom);
            logic [LANES-1:0] fl = ($urandom % 3 == 0) ? LANES'($urandom) : '0;
            bit v = ($urandom % 4) != 0;
            bit w = $urandom % 2;
            bit chk = ($urandom % 5) != 0;
            bit odd = $urandom % 2;
            xfer_valid = v; xfer_write = w; lane_en = en; cfg_chk_en = chk; cfg_odd = odd;
            wr_data = d; #1;
            check_par(odd ? "R3 R4 random" : "R2 R4 random");
            cycle(v, w, en, chk, odd, d, fl);
            check_err(v ? (w ? "R8 random" : "R5 R6 R7 random") : "R9 random");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule